// File: doc/BRIEF.md
# Combination Lock Controller with Lockout

This block decides whether a two-digit decimal code set on eight switch lines opens a lock. The correct code is a build-time constant, one BCD digit per 4-bit nibble, and no logic ever writes it. A user press on the try button is synchronized, reduced to a single-cycle event and used to sample the switches once. A correct code opens the lock and lights the green indication for a fixed window of clock cycles. A wrong code lights the red indication for the same window and adds one to a failure count.

Three wrong tries in a row latch the lock shut and raise the alarm. While latched, further tries have no effect of any kind. Only a press of the administrator button, which passes through its own synchronizer, clears the count and the latch. A correct try resets the count, so only unbroken runs of failures lead to lockout.

The block carries no streaming data, so it has no valid/ready handshake and applies no back-pressure. The switch lines are plain levels sampled in the cycle of the try event, and every output is a plain status level.

Top module: `combo_lock_ctrl`

## Requirements
- R1: An attempt is judged correct only when every 4-bit digit of `code_in` equals the matching digit of the parameter `KEY_BCD` (default 8'h47). Bits [3:0] form the low digit and bits [7:4] the high digit. A difference in either digit makes the attempt wrong.
- R2: Each rising edge of `try_btn` makes exactly one attempt. The edge is taken through a two-flop synchronizer, and its result appears on the outputs after the third rising clock edge that follows the change. Holding the button high adds no further attempts, and when no event occurs the count and the lock do not change.
- R3: A correct attempt drives `open_o` and `green_o` high and `red_o` low for exactly `OPEN_CYCLES` clock cycles.
- R4: A wrong attempt while unlocked drives `red_o` high, and `open_o` and `green_o` low, for exactly `OPEN_CYCLES` cycles, and it adds one to `fail_cnt_o`.
- R5: When `fail_cnt_o` reaches `MAX_FAILS` (default 3), `locked_o` and `alarm_o` go high in the same cycle and stay high.
- R6: While `locked_o` is high, a try event changes nothing: `open_o` stays low, no new red window starts and `fail_cnt_o` holds its value.
- R7: A rising edge of `admin_btn` clears `fail_cnt_o`, `locked_o`, `alarm_o`, `open_o`, `green_o` and `red_o`. It is synchronized in the same way as the try button.
- R8: A correct attempt clears `fail_cnt_o` to zero.
- R9: A try event during an active window restarts the window with the new attempt's result and a full `OPEN_CYCLES` length.
- R10: When an administrator event and a try event fall in the same cycle, the administrator event wins and the attempt is discarded.
- R11: While `rst_n` is low, all outputs are low and `fail_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| try_btn | input | 1 | Try button level, asynchronous |
| admin_btn | input | 1 | Administrator clear button level, asynchronous |
| code_in | input | 8 | User code, two BCD digits, high digit in [7:4] |
| open_o | output | 1 | Lock release pulse, high for the open window |
| green_o | output | 1 | Correct-code indicator |
| red_o | output | 1 | Wrong-code indicator |
| alarm_o | output | 1 | Alarm while locked out |
| locked_o | output | 1 | Lockout latch state |
| fail_cnt_o | output | 2 | Consecutive failed attempts |

## Verification
The administrator clear and a try evaluation can land in the same cycle. The bench provokes this by raising both buttons at one clock edge, so that their synchronized events coincide exactly. It does so with a wrong code two failures into a run, where honouring the try would have pushed the count to three. The case is judged at the ports: the count must read zero, the lock must be open and no red or open window may have started. A second collision, a try event arriving while an earlier window is still running, is judged by the outputs flipping to the new result and holding for a full window from the restart.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_GOOD = 2'd1,
    WIN_BAD  = 2'd2
  } win_kind_t;
endpackage

// File: rtl/lock_edge_sync.sv
module lock_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic evt
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], btn};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign evt = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lock_key_cmp.sv
module lock_key_cmp #(
  parameter int DIGITS = 2,
  parameter int NIB_W  = 4,
  parameter logic [DIGITS*NIB_W-1:0] KEY_BCD = 8'h47
) (
  input  logic [DIGITS*NIB_W-1:0] code,
  output logic                    match
);
  logic [DIGITS-1:0] dig_eq;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign dig_eq[d] = (code[d*NIB_W +: NIB_W] == KEY_BCD[d*NIB_W +: NIB_W]);
  end

  assign match = &dig_eq;
endmodule

// File: rtl/lock_fail_ctr.sv
module lock_fail_ctr #(
  parameter int MAX_FAILS = 3,
  localparam int CNT_W = $clog2(MAX_FAILS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             good,
  input  logic             bad,
  output logic [CNT_W-1:0] cnt,
  output logic             locked
);
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (good) begin
      cnt <= '0;
    end else if (bad) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == CNT_W'(MAX_FAILS)) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/lock_window_tmr.sv
module lock_window_tmr
  import lock_pkg::*;
#(
  parameter int OPEN_CYCLES = 300_000_000,
  localparam int TMR_W = $clog2(OPEN_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      start_good,
  input  logic      start_bad,
  output win_kind_t kind
);
  logic [TMR_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind   <= WIN_IDLE;
      left_q <= '0;
    end else if (clr) begin
      kind   <= WIN_IDLE;
      left_q <= '0;
    end else if (start_good || start_bad) begin
      kind   <= start_good ? WIN_GOOD : WIN_BAD;
      left_q <= TMR_W'(OPEN_CYCLES - 1);
    end else if (kind != WIN_IDLE) begin
      if (left_q == '0) kind <= WIN_IDLE;
      else              left_q <= left_q - TMR_W'(1);
    end
  end
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import lock_pkg::*;
#(
  parameter int DIGITS      = 2,
  parameter int NIB_W       = 4,
  parameter logic [DIGITS*NIB_W-1:0] KEY_BCD = 8'h47,
  parameter int MAX_FAILS   = 3,
  parameter int OPEN_CYCLES = 300_000_000,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = DIGITS * NIB_W,
  localparam int CNT_W  = $clog2(MAX_FAILS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              try_btn,
  input  logic              admin_btn,
  input  logic [CODE_W-1:0] code_in,
  output logic              open_o,
  output logic              green_o,
  output logic              red_o,
  output logic              alarm_o,
  output logic              locked_o,
  output logic [CNT_W-1:0]  fail_cnt_o
);
  localparam int BTN_TRY = 0;
  localparam int BTN_ADM = 1;
  localparam int N_BTN   = 2;

  logic [N_BTN-1:0] btn_lvl;
  logic [N_BTN-1:0] btn_evt;
  logic             try_evt;
  logic             adm_evt;
  logic             match;
  logic             try_ok;
  win_kind_t        kind;

  assign btn_lvl[BTN_TRY] = try_btn;
  assign btn_lvl[BTN_ADM] = admin_btn;

  for (genvar b = 0; b < N_BTN; b++) begin : g_btn
    lock_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .btn  (btn_lvl[b]),
      .evt  (btn_evt[b])
    );
  end

  assign try_evt = btn_evt[BTN_TRY];
  assign adm_evt = btn_evt[BTN_ADM];

  lock_key_cmp #(.DIGITS(DIGITS), .NIB_W(NIB_W), .KEY_BCD(KEY_BCD)) u_cmp (
    .code (code_in),
    .match(match)
  );

  // administrator event outranks a simultaneous try; lockout swallows tries
  assign try_ok = try_evt & ~adm_evt & ~locked_o;

  lock_fail_ctr #(.MAX_FAILS(MAX_FAILS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (adm_evt),
    .good  (try_ok & match),
    .bad   (try_ok & ~match),
    .cnt   (fail_cnt_o),
    .locked(locked_o)
  );

  lock_window_tmr #(.OPEN_CYCLES(OPEN_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (adm_evt),
    .start_good(try_ok & match),
    .start_bad (try_ok & ~match),
    .kind      (kind)
  );

  assign green_o = (kind == WIN_GOOD);
  assign open_o  = green_o;
  assign red_o   = (kind == WIN_BAD);
  assign alarm_o = locked_o;
endmodule

// File: rtl/lock_ctrl_chk.sv
module lock_ctrl_chk #(
  parameter logic [7:0] KEY_BCD = 8'h47,
  parameter int MAX_FAILS = 3,
  localparam int CNT_W = $clog2(MAX_FAILS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             try_evt,
  input logic             adm_evt,
  input logic [7:0]       code_in,
  input logic             open_o,
  input logic             green_o,
  input logic             red_o,
  input logic             alarm_o,
  input logic             locked_o,
  input logic [CNT_W-1:0] fail_cnt_o
);
  // R3, R8
  p_good_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (try_evt && !adm_evt && !locked_o && code_in == KEY_BCD)
      |=> (open_o && green_o && !red_o && fail_cnt_o == '0));

  // R4
  p_bad_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (try_evt && !adm_evt && !locked_o && code_in != KEY_BCD)
      |=> (red_o && !open_o && fail_cnt_o == $past(fail_cnt_o) + CNT_W'(1)));

  // R5
  p_lock_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> (fail_cnt_o == CNT_W'(MAX_FAILS) && alarm_o));

  // R6
  p_locked_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !adm_evt) |=> (locked_o && $stable(fail_cnt_o) && !open_o));

  // R7, R10
  p_admin_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adm_evt |=> (!locked_o && fail_cnt_o == '0 && !open_o && !red_o && !alarm_o));

  // R2
  p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!try_evt && !adm_evt) |=> ($stable(fail_cnt_o) && $stable(locked_o)));
endmodule

bind combo_lock_ctrl lock_ctrl_chk #(.KEY_BCD(KEY_BCD), .MAX_FAILS(MAX_FAILS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .try_evt   (try_evt),
  .adm_evt   (adm_evt),
  .code_in   (code_in),
  .open_o    (open_o),
  .green_o   (green_o),
  .red_o     (red_o),
  .alarm_o   (alarm_o),
  .locked_o  (locked_o),
  .fail_cnt_o(fail_cnt_o)
);

// File: tb/tb_combo_lock_ctrl.sv
module tb_combo_lock_ctrl;
  localparam int OPEN_N = 16;
  localparam logic [7:0] KEY = 8'h47;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic try_btn = 1'b0;
  logic admin_btn = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic open_o, green_o, red_o, alarm_o, locked_o;
  logic [1:0] fail_cnt_o;

  combo_lock_ctrl #(.KEY_BCD(KEY), .OPEN_CYCLES(OPEN_N)) dut (
    .clk(clk), .rst_n(rst_n), .try_btn(try_btn), .admin_btn(admin_btn),
    .code_in(code_in), .open_o(open_o), .green_o(green_o), .red_o(red_o),
    .alarm_o(alarm_o), .locked_o(locked_o), .fail_cnt_o(fail_cnt_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit exp_lock = 1'b0;
  bit exp_g = 1'b0;
  bit exp_r = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " open"}, int'(open_o), int'(exp_g));
    chk({req, " green"}, int'(green_o), int'(exp_g));
    chk({req, " red"}, int'(red_o), int'(exp_r));
    chk({req, " alarm"}, int'(alarm_o), int'(exp_lock));
    chk({req, " locked"}, int'(locked_o), int'(exp_lock));
    chk({req, " count"}, int'(fail_cnt_o), exp_cnt);
  endtask

  function automatic bit is_key(input logic [7:0] c);
    return (c[3:0] == KEY[3:0]) && (c[7:4] == KEY[7:4]);
  endfunction

  // model of one event; windows are assumed to have expired unless restarted
  task automatic model(input logic [7:0] c, input bit adm, input bit tr);
    if (adm) begin
      exp_cnt = 0; exp_lock = 1'b0; exp_g = 1'b0; exp_r = 1'b0;
    end else if (tr && !exp_lock) begin
      if (is_key(c)) begin
        exp_cnt = 0; exp_g = 1'b1; exp_r = 1'b0;
      end else begin
        exp_cnt++; exp_g = 1'b0; exp_r = 1'b1;
        if (exp_cnt == 3) exp_lock = 1'b1;
      end
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge where the result is visible
  task automatic press(input logic [7:0] c, input bit adm, input bit tr);
    code_in = c; try_btn = tr; admin_btn = adm;
    tick(3);
    try_btn = 1'b0; admin_btn = 1'b0;
    model(c, adm, tr);
  endtask

  task automatic settle();
    tick(OPEN_N + 2);
    exp_g = 1'b0; exp_r = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(2);
    chk_all("R11 reset");
    rst_n = 1'b1;
    tick(2);
    chk_all("R11 after release");

    // R3/R1: correct code and exact window length
    press(KEY, 1'b0, 1'b1);
    chk_all("R3 open start");
    tick(OPEN_N - 1);
    chk_all("R3 last open cycle");
    tick(1);
    exp_g = 1'b0;
    chk_all("R3 window end");

    // R1: each digit alone wrong, R4
    press({KEY[7:4], 4'h8}, 1'b0, 1'b1);
    chk_all("R1 low digit wrong R4");
    tick(OPEN_N - 1);
    chk_all("R4 last red cycle");
    tick(1);
    exp_r = 1'b0;
    chk_all("R4 window end");
    press({4'h9, KEY[3:0]}, 1'b0, 1'b1);
    chk_all("R1 high digit wrong");
    settle();

    // R8: correct try clears count
    press(KEY, 1'b0, 1'b1);
    chk_all("R8 clear on good");
    settle();

    // R2: holding the button makes one attempt
    code_in = 8'h11; try_btn = 1'b1;
    tick(3);
    model(8'h11, 1'b0, 1'b1);
    tick(10);
    try_btn = 1'b0;
    chk_all("R2 held press single attempt");
    settle();
    chk_all("R2 quiet");

    // R9: restart during a window
    press(KEY, 1'b0, 1'b1);
    tick(5);
    press(8'h22, 1'b0, 1'b1);
    chk_all("R9 restart to red");
    tick(OPEN_N - 1);
    chk_all("R9 full window after restart");
    tick(1);
    exp_r = 1'b0;
    chk_all("R9 end");

    // R10: admin and try together with count at 2
    press(8'h33, 1'b0, 1'b1);
    settle();
    chk("R10 precondition count", int'(fail_cnt_o), 2);
    press(8'h44, 1'b1, 1'b1);
    chk_all("R10 admin wins");
    settle();

    // R5/R6: lockout then ignored tries, R7 clear
    press(8'h01, 1'b0, 1'b1); settle();
    press(8'h02, 1'b0, 1'b1); settle();
    press(8'h03, 1'b0, 1'b1);
    chk_all("R5 lock on third");
    settle();
    press(KEY, 1'b0, 1'b1);
    chk_all("R6 good ignored while locked");
    press(8'h05, 1'b0, 1'b1);
    chk_all("R6 bad ignored while locked");
    tick(40);
    chk_all("R5 alarm continuous");
    press(8'h00, 1'b1, 1'b0);
    chk_all("R7 admin clear");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int sel = int'($urandom_range(0, 9));
      logic [7:0] c = (sel < 4) ? KEY : 8'($urandom);
      bit adm = (sel == 9);
      press(c, adm, 1'b1);
      chk_all(adm ? "R10 random admin" : "R4 random try");
      settle();
      chk_all("R6 random quiet");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule